// File: doc/BRIEF.md
# MicroWire Serial Master Controller

This block is a half-duplex serial master with four chip-select lines, reached through a small 16-bit register port. Software loads a transmit word, picks the divider, edge and polarity settings for each chip select, and then writes one command word. That command word selects a chip select, asserts it, and optionally starts a transfer. A transfer shifts out between 0 and 16 bits, then samples between 0 and 16 bits from the slave, all within one chip-select assertion.

The serial clock comes from the functional clock through two divider stages. The first stage is shared by all chip selects. The second stage is set per chip select. A busy flag covers the whole transfer. A read-ready flag reports that a received word is waiting in the receive register. The chip-select line stays asserted after a transfer until a later command deasserts it, so software can chain several words into one slave access.

Top module: `mw_master`

## Requirements
- R1: After reset, the command/status register (index 1) and the receive register (index 0) read 0, `sclk` and `sdo` are low, and all `cs_o` lines are high, since the default polarity is active-low.
- R2: Setup registers at indices 2 and 3 store 12 bits, index 4 stores 3 bits and index 5 stores 1 bit, all read back right-aligned with zero upper bits. Index 6 reads 0.
- R3: A command write (index 1) with bit 12 set asserts the chip select numbered in bits 11:10, and a write with bit 12 clear deasserts it. Each chip select has a 6-bit mode field: even chip selects use bits 5:0 and odd chip selects use bits 11:6, in setup index 2 for chip selects 0/1 and in setup index 3 for chip selects 2/3. Mode bit 2 set makes that line active-high. The inactive level is the complement of the active level.
- R4: A command write while busy is ignored, including its chip-select fields and its start bit.
- R5: A start (command bit 13) is ignored while bit 0 of setup index 4 is 0, and `sclk` then stays at its idle level.
- R6: The serial clock period is D1×D2 functional clock cycles. D1 is chosen by bits 2:1 of setup index 4 (0→2, 1→4, 2→7, 3→10). D2 is chosen by mode bits 4:3 (0→2, 1→4, 2→8).
- R7: Command bits 9:5 give the write count N. Transmit bits 15 down to 16−N are sent MSB first. The data changes on the rising clock edge when mode bit 1 is set, and on the falling edge otherwise (edges named before inversion). `sdo` is low whenever the block is not busy.
- R8: Command bits 4:0 give the read count M. `sdi` is sampled on the falling edge when mode bit 0 is set, and on the rising edge otherwise. The M bits land right-justified in the receive register, last bit in bit 0, upper bits 0.
- R9: When both counts are non-zero, the write bits precede the read bits in one transfer of N+M clock periods. Counts above 16 act as 16.
- R10: Busy (status bit 14) is set from the start until the last falling edge. Read-ready (bit 15) is set when a transfer with M>0 ends, and it is cleared by a read of index 0 or by a new start.
- R11: Bit 0 of setup index 5 inverts `sclk`, which makes the idle level high.
- R12: With mode bit 5 set, a started transfer stays busy with no clock edges until `sdi` is high.
- R13: A start with both counts zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 3 | Register index |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on index 0 only) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `reg_sel`, combinational |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to slave |
| sdi | input | 1 | Serial data from slave |
| cs_o | output | 4 | Chip-select lines, polarity per mode field |

## Verification
Some rules are checked by the assertions on every cycle. The chip-select fields must not move while a transfer runs. `sclk` and `sdo` must rest at idle whenever the engine is idle. A transfer may begin only with the prescaler enabled. Read-ready may rise only as busy falls, and the bit index must stay inside the programmed length. Other behaviours can only be shown by the bench scenarios, which act as a slave. These are the bit order and justification of the data in each edge mode, the exact clock period for each divider pairing, the ordering of write then read, the clamping of counts, the gating by `sdi` and the mode-field packing. The bench recovers the data from the pins and compares it with what the register settings predict.

// File: rtl/mw_master.sv
module mw_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        sclk,
  output logic        sdo,
  input  logic        sdi,
  output logic [3:0]  cs_o
);
  localparam int DW = 16;
  localparam int CW = $clog2(DW) + 1;
  localparam logic [CW:0] ONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;

  state_t        st;
  logic [DW-1:0] txd, rxd, tx_sh, rx_sh;
  logic [11:0]   sr1, sr2;
  logic [2:0]    sr3;
  logic          sr4;
  logic          rdy, cs_act;
  logic [1:0]    cs_idx;
  logic [CW-1:0] wcnt, rcnt, wn, rn;
  logic [CW:0]   bidx;
  logic [3:0]    mode_q;
  logic [1:0]    d1_q;
  logic [3:0]    c1;
  logic [1:0]    c2;
  logic          sclk_i;

  function automatic logic [4:0] cfg_of(input logic [1:0] k, input logic [11:0] a,
                                        input logic [11:0] b);
    logic [11:0] r;
    logic [5:0]  f;
    r = k[1] ? b : a;
    f = k[0] ? r[11:6] : r[5:0];
    return {f[5:3], f[1:0]};
  endfunction

  function automatic logic [CW-1:0] clamp(input logic [4:0] v);
    return (v > 5'd16) ? CW'(16) : CW'(v);
  endfunction

  logic          busy, wr_cmd, go;
  logic [CW-1:0] wn_new, rn_new;
  logic [4:0]    m_new;

  assign busy   = (st != S_IDLE);
  assign wr_cmd = wr_en && reg_sel == 3'd1 && !busy;
  assign wn_new = clamp(wdata[9:5]);
  assign rn_new = clamp(wdata[4:0]);
  assign m_new  = cfg_of(wdata[11:10], sr1, sr2);
  assign go     = wr_cmd && wdata[13] && sr3[0] && (wn_new != '0 || rn_new != '0);

  logic [3:0] c1_lim;
  logic [1:0] c2_lim;

  always_comb begin
    case (d1_q)
      2'd0:    c1_lim = 4'd1;
      2'd1:    c1_lim = 4'd3;
      2'd2:    c1_lim = 4'd6;
      default: c1_lim = 4'd9;
    endcase
    case (mode_q[3:2])
      2'd0:    c2_lim = 2'd0;
      2'd1:    c2_lim = 2'd1;
      default: c2_lim = 2'd3;
    endcase
  end

  logic          t1, ht, e_rise, e_fall, in_wr, last, wr_last, samp;
  logic [CW:0]   tot;
  logic [DW-1:0] rx_nx;

  assign t1      = (st == S_RUN) && (c1 == c1_lim);
  assign ht      = t1 && (c2 == c2_lim);
  assign e_rise  = ht && !sclk_i;
  assign e_fall  = ht && sclk_i;
  assign tot     = {1'b0, wn} + {1'b0, rn};
  assign in_wr   = bidx < {1'b0, wn};
  assign last    = (bidx + ONE) == tot;
  assign wr_last = (bidx + ONE) == {1'b0, wn};
  assign samp    = mode_q[0] ? e_fall : e_rise;
  assign rx_nx   = {rx_sh[DW-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      txd    <= '0;
      rxd    <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sr1    <= '0;
      sr2    <= '0;
      sr3    <= '0;
      sr4    <= 1'b0;
      rdy    <= 1'b0;
      cs_act <= 1'b0;
      cs_idx <= '0;
      wcnt   <= '0;
      rcnt   <= '0;
      wn     <= '0;
      rn     <= '0;
      bidx   <= '0;
      mode_q <= '0;
      d1_q   <= '0;
      c1     <= '0;
      c2     <= '0;
      sclk_i <= 1'b0;
      sdo    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (reg_sel)
          3'd0:    txd <= wdata;
          3'd2:    sr1 <= wdata[11:0];
          3'd3:    sr2 <= wdata[11:0];
          3'd4:    sr3 <= wdata[2:0];
          3'd5:    sr4 <= wdata[0];
          default: ;
        endcase
      end
      if (wr_cmd) begin
        cs_act <= wdata[12];
        cs_idx <= wdata[11:10];
        wcnt   <= wdata[9:5];
        rcnt   <= wdata[4:0];
      end
      if (rd_en && reg_sel == 3'd0) rdy <= 1'b0;

      case (st)
        S_IDLE: begin
          if (go) begin
            st     <= m_new[4] ? S_WAIT : S_RUN;
            wn     <= wn_new;
            rn     <= rn_new;
            mode_q <= m_new[3:0];
            d1_q   <= sr3[2:1];
            bidx   <= '0;
            c1     <= '0;
            c2     <= '0;
            sclk_i <= 1'b0;
            rx_sh  <= '0;
            rdy    <= 1'b0;
            if (wn_new != '0 && !m_new[1]) begin
              sdo   <= txd[DW-1];
              tx_sh <= txd << 1;
            end else begin
              tx_sh <= txd;
            end
          end
        end
        S_WAIT: begin
          if (sdi) st <= S_RUN;
        end
        default: begin
          c1 <= t1 ? 4'd0 : c1 + 4'd1;
          if (t1) c2 <= ht ? 2'd0 : c2 + 2'd1;
          if (ht) sclk_i <= ~sclk_i;
          if (e_rise && in_wr && mode_q[1]) begin
            sdo   <= tx_sh[DW-1];
            tx_sh <= tx_sh << 1;
          end
          if (e_fall && in_wr) begin
            if (wr_last) begin
              sdo <= 1'b0;
            end else if (!mode_q[1]) begin
              sdo   <= tx_sh[DW-1];
              tx_sh <= tx_sh << 1;
            end
          end
          if (samp && !in_wr) rx_sh <= rx_nx;
          if (e_fall) begin
            bidx <= bidx + ONE;
            if (last) begin
              st <= S_IDLE;
              if (rn != '0) begin
                rxd <= mode_q[0] ? rx_nx : rx_sh;
                rdy <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assign sclk = sclk_i ^ sr4;

  for (genvar i = 0; i < 4; i++) begin : g_cs
    logic pol;
    assign pol     = (i < 2) ? sr1[(i % 2) * 6 + 2] : sr2[(i % 2) * 6 + 2];
    assign cs_o[i] = (cs_act && cs_idx == 2'(i)) ? pol : ~pol;
  end

  always_comb begin
    case (reg_sel)
      3'd0:    rdata = rxd;
      3'd1:    rdata = {rdy, busy, 1'b0, cs_act, cs_idx, wcnt, rcnt};
      3'd2:    rdata = {4'd0, sr1};
      3'd3:    rdata = {4'd0, sr2};
      3'd4:    rdata = {13'd0, sr3};
      3'd5:    rdata = {15'd0, sr4};
      default: rdata = '0;
    endcase
  end

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cs_idx) && $stable(cs_act)); // R4
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_i); // R11
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo); // R7
  AST_START_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sr3[0])); // R5
  AST_RDY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $fell(busy)); // R10
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bidx < tot); // R9
endmodule

// File: tb/test_mw_master.sv
module test_mw_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sclk, sdo;
  logic        sdi = 1'b1;
  logic [3:0]  cs_o;

  int checks = 0;
  int errors = 0;
  logic [11:0] sh1 = '0, sh2 = '0;
  logic inv = 1'b0;

  mw_master i_mw_master (.*);

  always #4 clk = ~clk;

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] s, output logic [15:0] d);
    @(negedge clk);
    reg_sel = s; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [15:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = rdata;
  endtask

  task automatic set_mode(input int cs, input logic [5:0] m);
    if (cs < 2) begin
      if (cs % 2 == 1) sh1[11:6] = m; else sh1[5:0] = m;
      bus_wr(3'd2, {4'd0, sh1});
    end else begin
      if (cs % 2 == 1) sh2[11:6] = m; else sh2[5:0] = m;
      bus_wr(3'd3, {4'd0, sh2});
    end
  endtask

  task automatic xfer(input logic [1:0] cs, input logic [4:0] wf, input logic [4:0] rf,
                      input int wn_e, input int rn, input logic [15:0] tx,
                      input logic [15:0] pat, input int per, input bit drise,
                      input bit poke, input bit hold, input string req);
    int cyc = 0, falls = 0, lastr = -1, perr = 0, cserr = 0, early = 0;
    logic [15:0] cap = '0;
    logic [15:0] d;
    logic [3:0] cs_exp;
    logic prev_s, prev_sdo, s;
    bus_wr(3'd0, tx);
    sdi = (wn_e == 0 && rn > 0) ? pat[rn-1] : 1'b1;
    if (hold) sdi = 1'b0;
    bus_wr(3'd1, {3'b001, 1'b1, cs, wf, rf});
    reg_sel = 3'd1;
    #1;
    cs_exp = cs_o; prev_s = sclk ^ inv; prev_sdo = sdo;
    while (rdata[14] && cyc < 6000) begin
      @(negedge clk);
      #1;
      cyc++;
      if (poke) begin
        if (cyc == 3) begin
          wdata = {3'b001, 1'b1, cs ^ 2'b01, 5'd1, 5'd1};
          wr_en = 1'b1;
        end else wr_en = 1'b0;
      end
      s = sclk ^ inv;
      if (cs_o !== cs_exp) cserr++;
      if (s != prev_s) begin
        if (hold && cyc <= 40) early++;
        if (s) begin
          if (lastr >= 0 && cyc - lastr != per) perr++;
          lastr = cyc;
          if (!drise && falls < wn_e) cap = {cap[14:0], prev_sdo};
        end else begin
          if (drise && falls < wn_e) cap = {cap[14:0], prev_sdo};
          falls++;
        end
      end
      if (!(hold && cyc < 40))
        sdi = (falls >= wn_e && falls < wn_e + rn) ? pat[rn-1-(falls-wn_e)] : 1'b1;
      prev_s = s; prev_sdo = sdo;
      #1;
    end
    wr_en = 1'b0;
    chk(cyc < 6000, {req, " R10 busy clears"}, cyc, 0);
    chk(falls == wn_e + rn, {req, " R9 clock count"}, falls, wn_e + rn);
    chk(perr == 0, {req, " R6 period"}, perr, 0);
    chk(cserr == 0, {req, " R4 cs steady"}, cserr, 0);
    chk(sdo == 1'b0, {req, " R7 sdo idle"}, sdo, 0);
    if (hold) chk(early == 0, {req, " R12 held off"}, early, 0);
    if (wn_e > 0)
      chk((int'(cap) & ((32'd1 << wn_e) - 1)) == (int'(tx) >> (16 - wn_e)),
          {req, " R7 tx bits"}, int'(cap) & ((32'd1 << wn_e) - 1), int'(tx) >> (16 - wn_e));
    if (rn > 0) begin
      peek(3'd1, d);
      chk(d[15] == 1'b1, {req, " R10 ready set"}, d[15], 1);
      bus_rd(3'd0, d);
      chk(int'(d) == (int'(pat) & ((32'd1 << rn) - 1)), {req, " R8 rx word"},
          d, int'(pat) & ((32'd1 << rn) - 1));
      peek(3'd1, d);
      chk(d[15] == 1'b0, {req, " R10 ready cleared"}, d[15], 0);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    peek(3'd1, d); chk(d == 16'h0, "R1 status", d, 0);
    peek(3'd0, d); chk(d == 16'h0, "R1 rx", d, 0);
    chk(cs_o == 4'hF && !sclk && !sdo, "R1 pins", {cs_o, sclk, sdo}, 8'h3C);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    bus_wr(3'd2, 16'hF123); peek(3'd2, d); chk(d == 16'h0123, "R2 setup idx2", d, 16'h0123);
    bus_wr(3'd4, 16'hFFFF); peek(3'd4, d); chk(d == 16'h0007, "R2 setup idx4", d, 7);
    bus_wr(3'd5, 16'hFFFF); peek(3'd5, d); chk(d == 16'h0001, "R2 setup idx5", d, 1);
    bus_wr(3'd6, 16'hFFFF); peek(3'd6, d); chk(d == 16'h0000, "R2 setup idx6", d, 0);
    bus_wr(3'd2, 16'h0); bus_wr(3'd4, 16'h0); bus_wr(3'd5, 16'h0);
  endtask

  task automatic t_cs;
    bus_wr(3'd1, {4'b0001, 2'd2, 10'd0}); #1;
    chk(cs_o == 4'b1011, "R3 cs2 low", cs_o, 4'b1011);
    set_mode(3, 6'b000100);
    bus_wr(3'd1, {4'b0001, 2'd3, 10'd0}); #1;
    chk(cs_o == 4'b1111, "R3 cs3 active high", cs_o, 4'b1111);
    bus_wr(3'd1, {4'b0000, 2'd3, 10'd0}); #1;
    chk(cs_o == 4'b0111, "R3 cs3 deasserted", cs_o, 4'b0111);
    set_mode(3, 6'b0);
  endtask

  task automatic t_disabled;
    logic [15:0] d;
    int edges = 0;
    logic p;
    bus_wr(3'd4, 16'h0);
    bus_wr(3'd1, {4'b0011, 2'd0, 5'd8, 5'd0});
    p = sclk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk != p) edges++;
      p = sclk;
    end
    peek(3'd1, d);
    chk(d[14] == 1'b0, "R5 no busy when disabled", d[14], 0);
    chk(edges == 0, "R5 sclk quiet", edges, 0);
  endtask

  task automatic t_zero;
    logic [15:0] d;
    bus_wr(3'd4, 16'h1);
    bus_wr(3'd1, {4'b0011, 2'd0, 5'd0, 5'd0});
    peek(3'd1, d);
    chk(d[14] == 1'b0, "R13 zero counts ignored", d[14], 0);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_cs();
    t_disabled();
    t_zero();

    set_mode(0, 6'b000000);
    bus_wr(3'd4, {13'd0, 2'd0, 1'b1});
    xfer(2'd0, 5'd8, 5'd0, 8, 0, 16'hA53C, 16'h0, 4, 1'b0, 1'b0, 1'b0, "R7 write8 d4");

    set_mode(1, 6'b001011);
    bus_wr(3'd4, {13'd0, 2'd1, 1'b1});
    xfer(2'd1, 5'd0, 5'd12, 0, 12, 16'h0, 16'h0A5C, 16, 1'b1, 1'b0, 1'b0, "R8 read12 d16");

    set_mode(2, 6'b000010);
    bus_wr(3'd4, {13'd0, 2'd2, 1'b1});
    bus_wr(3'd5, 16'h1); inv = 1'b1;
    #1 chk(sclk == 1'b1, "R11 idle high", sclk, 1);
    xfer(2'd2, 5'd5, 5'd7, 5, 7, 16'hB800, 16'h0053, 14, 1'b1, 1'b0, 1'b0, "R9 w5r7 d14 inv");
    #1 chk(sclk == 1'b1, "R11 idle high after", sclk, 1);
    bus_wr(3'd5, 16'h0); inv = 1'b0;

    set_mode(3, 6'b010001);
    bus_wr(3'd4, {13'd0, 2'd3, 1'b1});
    xfer(2'd3, 5'd16, 5'd16, 16, 16, 16'h9C3E, 16'h6AD5, 80, 1'b0, 1'b1, 1'b0, "R9 w16r16 d80");
    peek(3'd1, d);
    chk(d[11:10] == 2'd3, "R4 poke ignored", d[11:10], 3);

    set_mode(0, 6'b100000);
    bus_wr(3'd4, {13'd0, 2'd0, 1'b1});
    xfer(2'd0, 5'd4, 5'd0, 4, 0, 16'hC000, 16'h0, 4, 1'b0, 1'b0, 1'b1, "R12 ready gate");

    set_mode(0, 6'b000000);
    xfer(2'd0, 5'd31, 5'd0, 16, 0, 16'hF00D, 16'h0, 4, 1'b0, 1'b0, 1'b0, "R9 clamp");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule